// File: doc/BRIEF.md
# Pluggable Module Reset and Interrupt Sequencer

This block runs the reset lifecycle of a pluggable module's management logic and drives the host interrupt line. The host's active-low reset pin passes through a synchronizer and a low-width filter, so that glitches and short low pulses are discarded. A low level that lasts long enough places the module in a held-reset state. In that state the user-writable settings are forced to their defaults and the latched interrupt flag is cleared. When the pin is released, an initialization interval of fixed length runs. A data-not-ready status bit stays set during that interval, and the host treats every other status bit as invalid until it clears.

When initialization ends, data-not-ready clears and an interrupt flag is latched. The flag drives the enable of an open-drain pull-down on the host interrupt line. Power-on alone runs the same initialization and posts the same completion interrupt, so no reset pulse is needed at power-up. The register interface reads the latched flag and clears it with a one-cycle strobe.

The controller has three states. ST_INIT is the timed initialization and is also the state entered at power-on. ST_HELD means a qualified reset is in force. ST_READY means the module is operational. The transitions are:

- INIT_DONE: ST_INIT to ST_READY, when the interval expires.
- HOLD_FROM_INIT: ST_INIT to ST_HELD, on a qualifying low.
- HOLD_FROM_READY: ST_READY to ST_HELD, on a qualifying low.
- PIN_RELEASE: ST_HELD to ST_INIT, when the synchronized pin reads high.

Top module: `plug_rst_seq`

## Requirements
- R1: After power-on reset, data_not_ready reads 1, and irq_flag, int_pull_low and cfg_to_default read 0. Exactly INIT_CYC clock edges after por_n is released, data_not_ready falls and the interrupt is posted, with no reset pulse applied.
- R2: A low on rst_pin_n that lasts MIN_LOW_CYC cycles or fewer has no effect in ST_INIT or in ST_READY. In ST_INIT the interval keeps its original end time. In ST_READY data_not_ready stays 0, a set irq_flag stays set, and cfg_to_default stays 0.
- R3: A low on rst_pin_n of at least MIN_LOW_CYC+1 cycles enters ST_HELD on the edge MIN_LOW_CYC+3 cycles after the pin falls (two synchronizer stages and one state edge). In ST_HELD, cfg_to_default=1, data_not_ready=1, and irq_flag and int_pull_low are 0.
- R4: After the pin rises, ST_HELD lasts until the third clock edge, then ST_INIT runs for exactly INIT_CYC cycles. cfg_to_default is 0 and data_not_ready is 1 throughout ST_INIT.
- R5: On the edge that ends ST_INIT, data_not_ready falls and irq_flag and int_pull_low rise together.
- R6: irq_flag stays set until an irq_clr strobe or a qualified reset. An irq_clr strobe seen on an edge in ST_READY clears irq_flag and releases int_pull_low on that edge.
- R7: A qualifying low during ST_INIT restarts the sequence. The block re-enters ST_HELD, and completion moves to INIT_CYC cycles after the new release.
- R8: int_pull_low is never asserted while data_not_ready is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_pin_n | input | 1 | Host reset pin, active low, asynchronous; reads high (idle) when not driven |
| irq_clr | input | 1 | One-cycle clear strobe for the latched interrupt flag |
| data_not_ready | output | 1 | Status bit, 1 while held in reset or initializing |
| irq_flag | output | 1 | Latched completion interrupt flag for the register interface |
| int_pull_low | output | 1 | Open-drain enable; 1 pulls the host interrupt line low |
| cfg_to_default | output | 1 | Forces user-writable settings to their defaults while 1 |

## Verification
Pin changes take two synchronizer edges to reach the controller. A qualifying low therefore shows on cfg_to_default at edge MIN_LOW_CYC+3 after the falling pin, and the release moves the block to ST_INIT at edge 3 after the rising pin. Completion comes exactly INIT_CYC edges after ST_INIT is entered, and an irq_clr strobe takes effect on the edge that samples it. Each scenario drives inputs on the falling clock edge and counts whole cycles from the stimulus. It samples the outputs one cycle before each due edge, to confirm nothing has changed yet, and again just after that edge, to confirm the change arrived.

// File: rtl/plug_rst_pkg.sv
`timescale 1ns/1ps
package plug_rst_pkg;
    typedef enum logic [1:0] {
        ST_INIT  = 2'd0,
        ST_HELD  = 2'd1,
        ST_READY = 2'd2
    } seq_state_e;
endpackage

// File: rtl/plug_rst_sync.sv
`timescale 1ns/1ps
module plug_rst_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            chain_q <= {STAGES{RESET_VAL}};
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_async};
        end
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/plug_rst_lowfilt.sv
`timescale 1ns/1ps
module plug_rst_lowfilt #(
    parameter int MIN_LOW = 4
) (
    input  logic clk,
    input  logic arst_n,
    input  logic lvl_n,
    output logic long_low
);
    localparam int CW = $clog2(MIN_LOW + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_LOW);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt_q <= '0;
        end else if (lvl_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != LIMIT) begin
            low_cnt_q <= low_cnt_q + 1'b1;
        end
    end

    assign long_low = !lvl_n && (low_cnt_q == LIMIT);
endmodule

// File: rtl/plug_rst_timer.sv
`timescale 1ns/1ps
module plug_rst_timer #(
    parameter int CYCLES = 10
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hold,
    output logic expired
);
    localparam int TW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [TW-1:0] LAST = TW'(CYCLES - 1);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            cnt_q <= '0;
        end else if (hold) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign expired = !hold && (cnt_q == LAST);
endmodule

// File: rtl/plug_rst_seq.sv
`timescale 1ns/1ps
module plug_rst_seq
    import plug_rst_pkg::*;
#(
    parameter int MIN_LOW_CYC = 4,
    parameter int INIT_CYC    = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por_n,
    input  logic rst_pin_n,
    input  logic irq_clr,
    output logic data_not_ready,
    output logic irq_flag,
    output logic int_pull_low,
    output logic cfg_to_default
);
    seq_state_e state_q;
    seq_state_e state_nxt;
    logic       pin_s;
    logic       long_low;
    logic       init_expired;
    logic       flag_q;
    logic       init_done;

    // Pin idles high when undriven, so the synchronizer resets to 1
    plug_rst_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) i_sync (
        .clk     (clk),
        .arst_n  (por_n),
        .d_async (rst_pin_n),
        .q_sync  (pin_s)
    );

    plug_rst_lowfilt #(
        .MIN_LOW (MIN_LOW_CYC)
    ) i_lowfilt (
        .clk      (clk),
        .arst_n   (por_n),
        .lvl_n    (pin_s),
        .long_low (long_low)
    );

    plug_rst_timer #(
        .CYCLES (INIT_CYC)
    ) i_timer (
        .clk     (clk),
        .arst_n  (por_n),
        .hold    (state_q != ST_INIT),
        .expired (init_expired)
    );

    // Next-state decode
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            ST_INIT: begin
                if (long_low) begin
                    state_nxt = ST_HELD;       // HOLD_FROM_INIT
                end else if (init_expired) begin
                    state_nxt = ST_READY;      // INIT_DONE
                end
            end
            ST_HELD: begin
                if (pin_s) begin
                    state_nxt = ST_INIT;       // PIN_RELEASE
                end
            end
            ST_READY: begin
                if (long_low) begin
                    state_nxt = ST_HELD;       // HOLD_FROM_READY
                end
            end
            default: state_nxt = ST_INIT;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_INIT;
        end else begin
            state_q <= state_nxt;
        end
    end

    assign init_done = (state_q == ST_INIT) && (state_nxt == ST_READY);

    // Latched interrupt flag: completion sets, clear strobe or held reset clears
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            flag_q <= 1'b0;
        end else if (init_done) begin
            flag_q <= 1'b1;
        end else if (irq_clr || (state_nxt == ST_HELD)) begin
            flag_q <= 1'b0;
        end
    end

    // Output decode
    always_comb begin
        data_not_ready = 1'b1;
        cfg_to_default = 1'b0;
        unique case (state_q)
            ST_INIT: begin
                data_not_ready = 1'b1;
                cfg_to_default = 1'b0;
            end
            ST_HELD: begin
                data_not_ready = 1'b1;
                cfg_to_default = 1'b1;
            end
            ST_READY: begin
                data_not_ready = 1'b0;
                cfg_to_default = 1'b0;
            end
            default: begin
                data_not_ready = 1'b1;
                cfg_to_default = 1'b0;
            end
        endcase
    end

    assign irq_flag     = flag_q;
    assign int_pull_low = flag_q;
endmodule

// File: rtl/plug_rst_seq_chk.sv
`timescale 1ns/1ps
module plug_rst_seq_chk (
    input logic clk,
    input logic por_n,
    input logic irq_clr,
    input logic data_not_ready,
    input logic irq_flag,
    input logic int_pull_low,
    input logic cfg_to_default
);
    AST_DEFAULTS_ONLY_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        cfg_to_default |-> data_not_ready); // R3

    AST_RELEASE_INTO_INIT: assert property (@(posedge clk) disable iff (!por_n)
        $fell(cfg_to_default) |-> data_not_ready); // R4

    AST_DONE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!por_n)
        $fell(data_not_ready) |-> (irq_flag && int_pull_low)); // R5

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!por_n)
        (!data_not_ready && irq_clr) |=> !irq_flag); // R6

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        (irq_flag && !irq_clr) |=> (irq_flag || cfg_to_default)); // R6

    AST_NO_IRQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!por_n)
        int_pull_low |-> !data_not_ready); // R8
endmodule

bind plug_rst_seq plug_rst_seq_chk i_chk (
    .clk            (clk),
    .por_n          (por_n),
    .irq_clr        (irq_clr),
    .data_not_ready (data_not_ready),
    .irq_flag       (irq_flag),
    .int_pull_low   (int_pull_low),
    .cfg_to_default (cfg_to_default)
);

// File: tb/test_plug_rst_seq.sv
`timescale 1ns/1ps
module test_plug_rst_seq;
    localparam int MIN_LOW = 4;
    localparam int INIT    = 10;

    logic clk = 1'b0;
    logic por_n;
    logic rst_pin_n;
    logic irq_clr;
    logic data_not_ready;
    logic irq_flag;
    logic int_pull_low;
    logic cfg_to_default;

    int n_chk = 0;
    int n_err = 0;

    always #2 clk = ~clk;

    plug_rst_seq #(
        .MIN_LOW_CYC (MIN_LOW),
        .INIT_CYC    (INIT),
        .SYNC_STAGES (2)
    ) i_plug_rst_seq (
        .clk            (clk),
        .por_n          (por_n),
        .rst_pin_n      (rst_pin_n),
        .irq_clr        (irq_clr),
        .data_not_ready (data_not_ready),
        .irq_flag       (irq_flag),
        .int_pull_low   (int_pull_low),
        .cfg_to_default (cfg_to_default)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
        $finish;
    endtask

    // Power-up without a reset pulse
    task automatic t_powerup();
        por_n = 1'b0; rst_pin_n = 1'b1; irq_clr = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "dnr in reset", data_not_ready, 1);
        chk("R1", "flag in reset", irq_flag, 0);
        chk("R1", "pull in reset", int_pull_low, 0);
        chk("R1", "defaults in reset", cfg_to_default, 0);
        por_n = 1'b1;
        repeat (INIT - 1) @(negedge clk);
        chk("R1", "dnr one cycle early", data_not_ready, 1);
        chk("R8", "pull while busy", int_pull_low, 0);
        @(negedge clk);
        chk("R1", "dnr after init", data_not_ready, 0);
        chk("R5", "flag at completion", irq_flag, 1);
        chk("R5", "pull at completion", int_pull_low, 1);
    endtask

    // Short pulse (exactly MIN_LOW) while ready
    task automatic t_short_ready();
        logic seen = 1'b0;
        rst_pin_n = 1'b0;
        for (int i = 0; i < MIN_LOW; i++) begin
            @(negedge clk);
            if (cfg_to_default || data_not_ready || !irq_flag) seen = 1'b1;
        end
        rst_pin_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (cfg_to_default || data_not_ready || !irq_flag) seen = 1'b1;
        end
        chk("R2", "short pulse disturbed ready", seen, 0);
        chk("R6", "flag still latched", irq_flag, 1);
    endtask

    // Long reset from ready, then release and init
    task automatic t_long_reset();
        rst_pin_n = 1'b0;
        repeat (2 + MIN_LOW) @(negedge clk);
        chk("R3", "defaults before qualify edge", cfg_to_default, 0);
        @(negedge clk);
        chk("R3", "defaults when held", cfg_to_default, 1);
        chk("R3", "dnr when held", data_not_ready, 1);
        chk("R3", "flag cleared when held", irq_flag, 0);
        chk("R3", "pull released when held", int_pull_low, 0);
        rst_pin_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R4", "still held before release edge", cfg_to_default, 1);
        @(negedge clk);
        chk("R4", "defaults off in init", cfg_to_default, 0);
        chk("R4", "dnr in init", data_not_ready, 1);
        repeat (INIT - 1) @(negedge clk);
        chk("R4", "dnr at last init cycle", data_not_ready, 1);
        chk("R8", "pull while busy", int_pull_low, 0);
        @(negedge clk);
        chk("R5", "dnr cleared", data_not_ready, 0);
        chk("R5", "flag set", irq_flag, 1);
        chk("R5", "pull set", int_pull_low, 1);
    endtask

    // Host clear strobe
    task automatic t_clear();
        repeat (3) @(negedge clk);
        chk("R6", "flag held before clear", irq_flag, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R6", "flag after clear", irq_flag, 0);
        chk("R6", "pull after clear", int_pull_low, 0);
        chk("R6", "dnr unaffected by clear", data_not_ready, 0);
    endtask

    // Bring the block to its first ST_INIT cycle via a long reset
    task automatic enter_init();
        rst_pin_n = 1'b0;
        repeat (MIN_LOW + 3) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Short pulse during init does not move completion
    task automatic t_short_init();
        enter_init();
        rst_pin_n = 1'b0;
        repeat (MIN_LOW) @(negedge clk);
        rst_pin_n = 1'b1;
        repeat (INIT - MIN_LOW - 1) @(negedge clk);
        chk("R2", "dnr before original end", data_not_ready, 1);
        chk("R2", "no hold from short pulse", cfg_to_default, 0);
        @(negedge clk);
        chk("R2", "completion on original time", data_not_ready, 0);
        chk("R5", "flag at completion", irq_flag, 1);
    endtask

    // Qualifying pulse of exactly MIN_LOW+1 during init restarts
    task automatic t_restart();
        enter_init();
        repeat (2) @(negedge clk);
        rst_pin_n = 1'b0;
        repeat (MIN_LOW + 1) @(negedge clk);
        rst_pin_n = 1'b1;
        @(negedge clk);
        chk("R7", "not held yet", cfg_to_default, 0);
        @(negedge clk);
        chk("R7", "held on restart", cfg_to_default, 1);
        chk("R7", "dnr on restart", data_not_ready, 1);
        repeat (INIT) @(negedge clk);
        chk("R7", "dnr before new end", data_not_ready, 1);
        chk("R8", "pull while busy", int_pull_low, 0);
        @(negedge clk);
        chk("R7", "completion after new init", data_not_ready, 0);
        chk("R7", "flag after restart", irq_flag, 1);
    endtask

    initial begin
        t_powerup();
        t_short_ready();
        t_long_reset();
        t_clear();
        t_short_init();
        t_restart();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule